// File: doc/BRIEF.md
# RAM Access Protection Violation Monitor

This block sits between a local CPU, a local DMA engine and a bank of on-chip RAM blocks. Every access carries the index of the RAM block it targets, already decoded from the address. Each block has three protection bits: CPU write, DMA write and CPU fetch. It also has an ownership bit that marks a shared block as held by the other subsystem. From these bits the block decides, in the same cycle, whether a write may reach the RAM and whether an instruction fetch is to be reported as a fault.

Each refused access is logged in one of two sticky three-bit flag registers. One register holds violations of a block this side owns (owner flags). The other holds accesses to a block the other subsystem owns (foreign flags). Software reads both registers over a small register bus. It clears flags through two write-one-to-clear registers, one for each flag register.

Top module: `ram_access_guard`

## Requirements
- R1: After reset, and after any later reset, both flag registers read 0.
- R2: Register map by `regAddr`: 0 is the owner flags, 1 is the foreign flags, 2 is the owner clear, 3 is the foreign clear. Within a flag word, bit 0 is CPU fetch, bit 1 is DMA write and bit 2 is CPU write. Bits 31 to 3 read 0, and both clear registers read 0.
- R3: A CPU write (`cpuKind`=1) to a block this side owns with its CPU-write protect bit at 1 sets owner bit 2, and `ramCpuWe` stays 0.
- R4: A DMA write to a block this side owns with its DMA-write protect bit at 1 sets owner bit 1, and `ramDmaWe` stays 0.
- R5: A CPU fetch (`cpuKind`=2) from a block this side owns with its fetch protect bit at 1 sets owner bit 0 and raises `fetchFault` in the same cycle.
- R6: A DMA write to a block owned by the other subsystem sets foreign bit 1 and is suppressed. The owner flags stay unchanged whatever that block's protect bits hold.
- R7: A CPU fetch from a block owned by the other subsystem sets foreign bit 0 and raises `fetchFault`.
- R8: A CPU write to a block owned by the other subsystem sets foreign bit 2 and is suppressed.
- R9: A permitted write asserts its RAM write enable in the same cycle as the request. A permitted fetch does not raise `fetchFault`. Neither sets a flag.
- R10: A flag stays 1 until software writes 1 to the matching bit of its own clear register. Writing 0 to a clear bit, writing to the other clear register, or writing to a flag register leaves the flag unchanged.
- R11: When a violation and a clear hit the same flag bit in the same cycle, the flag ends at 1.
- R12: A CPU read (`cpuKind`=0) never sets a flag, never raises `fetchFault` and never asserts `ramCpuWe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuValid | input | 1 | CPU access present this cycle |
| cpuKind | input | 2 | 0 read, 1 write, 2 fetch |
| cpuBlock | input | IDX_W | RAM block index of the CPU access |
| dmaValid | input | 1 | DMA access present this cycle |
| dmaWrite | input | 1 | DMA access is a write |
| dmaBlock | input | IDX_W | RAM block index of the DMA access |
| cfgCpuWrProt | input | NUM_BLOCKS | Per-block CPU write protect |
| cfgDmaWrProt | input | NUM_BLOCKS | Per-block DMA write protect |
| cfgFetchProt | input | NUM_BLOCKS | Per-block CPU fetch protect |
| cfgOtherOwns | input | NUM_BLOCKS | Per-block: shared block held by the other subsystem |
| ramCpuWe | output | 1 | CPU write enable passed to the RAM |
| ramDmaWe | output | 1 | DMA write enable passed to the RAM |
| fetchFault | output | 1 | Current CPU fetch is refused |
| regSel | input | 1 | Register access strobe |
| regWr | input | 1 | Register access is a write |
| regAddr | input | REG_AW | Register index |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data, combinational from `regAddr` |

## Verification
A wrong permission decision shows in the same cycle as the access. It appears as a write enable that should be low, or a missing or spurious `fetchFault`. A corrupted flag register shows on the first read after the clock edge that follows the access. The bench reads both flag words after every vector, so a flag set in the wrong register, at the wrong bit, or not held shows within two cycles. A lost clear or a clear that wins over a set shows on the read right after the clear write.

// File: rtl/ram_guard_pkg.sv
package ram_guard_pkg;
  localparam int FLAG_W = 3;
  localparam int FLAG_FETCH = 0;
  localparam int FLAG_DMAWR = 1;
  localparam int FLAG_CPUWR = 2;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2
  } acc_kind_e;

  typedef struct packed {
    logic [FLAG_W-1:0] setOwn;
    logic [FLAG_W-1:0] setNon;
    logic [FLAG_W-1:0] clrOwn;
    logic [FLAG_W-1:0] clrNon;
  } guard_strobe_t;
endpackage

// File: rtl/ram_guard_ctrl.sv
module ram_guard_ctrl
  import ram_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int IDX_W = 3,
  parameter int REG_AW = 2,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuValid,
  input  logic [1:0]            cpuKind,
  input  logic [IDX_W-1:0]      cpuBlock,
  input  logic                  dmaValid,
  input  logic                  dmaWrite,
  input  logic [IDX_W-1:0]      dmaBlock,
  input  logic [NUM_BLOCKS-1:0] cfgCpuWrProt,
  input  logic [NUM_BLOCKS-1:0] cfgDmaWrProt,
  input  logic [NUM_BLOCKS-1:0] cfgFetchProt,
  input  logic [NUM_BLOCKS-1:0] cfgOtherOwns,
  input  logic                  regSel,
  input  logic                  regWr,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic                  ramCpuWe,
  output logic                  ramDmaWe,
  output logic                  fetchFault,
  output guard_strobe_t         strobes
);
  localparam logic [REG_AW-1:0] ADDR_CLR_OWN = REG_AW'(2);
  localparam logic [REG_AW-1:0] ADDR_CLR_NON = REG_AW'(3);

  logic cpuIsWr, cpuIsFetch, dmaIsWr;
  logic cpuForeign, dmaForeign;
  logic ownCpuWr, nonCpuWr, ownFetch, nonFetch, ownDmaWr, nonDmaWr;
  logic regWrEn;

  always_comb begin
    cpuIsWr    = cpuValid && (cpuKind == KIND_WRITE);
    cpuIsFetch = cpuValid && (cpuKind == KIND_FETCH);
    dmaIsWr    = dmaValid && dmaWrite;
    cpuForeign = cfgOtherOwns[cpuBlock];
    dmaForeign = cfgOtherOwns[dmaBlock];

    // foreign ownership takes precedence over this side's protect bits
    ownCpuWr = cpuIsWr && !cpuForeign && cfgCpuWrProt[cpuBlock];
    nonCpuWr = cpuIsWr && cpuForeign;
    ownFetch = cpuIsFetch && !cpuForeign && cfgFetchProt[cpuBlock];
    nonFetch = cpuIsFetch && cpuForeign;
    ownDmaWr = dmaIsWr && !dmaForeign && cfgDmaWrProt[dmaBlock];
    nonDmaWr = dmaIsWr && dmaForeign;

    ramCpuWe   = cpuIsWr && !(ownCpuWr || nonCpuWr);
    ramDmaWe   = dmaIsWr && !(ownDmaWr || nonDmaWr);
    fetchFault = ownFetch || nonFetch;

    strobes.setOwn = '0;
    strobes.setNon = '0;
    strobes.setOwn[FLAG_CPUWR] = ownCpuWr;
    strobes.setOwn[FLAG_DMAWR] = ownDmaWr;
    strobes.setOwn[FLAG_FETCH] = ownFetch;
    strobes.setNon[FLAG_CPUWR] = nonCpuWr;
    strobes.setNon[FLAG_DMAWR] = nonDmaWr;
    strobes.setNon[FLAG_FETCH] = nonFetch;

    regWrEn = regSel && regWr;
    strobes.clrOwn = (regWrEn && regAddr == ADDR_CLR_OWN) ? regWdata[FLAG_W-1:0] : '0;
    strobes.clrNon = (regWrEn && regAddr == ADDR_CLR_NON) ? regWdata[FLAG_W-1:0] : '0;
  end

  // R3, R8: a write that reaches the RAM never raises a write flag
  a_r3_we_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    ramCpuWe |-> !strobes.setOwn[FLAG_CPUWR] && !strobes.setNon[FLAG_CPUWR]);
  // R4, R6: same for the DMA port
  a_r4_dma_we_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    ramDmaWe |-> !strobes.setOwn[FLAG_DMAWR] && !strobes.setNon[FLAG_DMAWR]);
  // R12: a fault or a CPU write enable only on the matching access kind
  a_r12_kind_match: assert property (@(posedge clk) disable iff (!rstN)
    (fetchFault |-> cpuValid && cpuKind == KIND_FETCH) and
    (ramCpuWe |-> cpuValid && cpuKind == KIND_WRITE));
  // R5, R7: a fault always logs exactly one fetch flag
  a_r5_fault_logged: assert property (@(posedge clk) disable iff (!rstN)
    fetchFault |-> $countones({strobes.setOwn[FLAG_FETCH], strobes.setNon[FLAG_FETCH]}) == 1);
endmodule

// File: rtl/ram_guard_flags.sv
module ram_guard_flags
  import ram_guard_pkg::*;
#(
  parameter int REG_AW = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobe_t     strobes,
  input  logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regRdata
);
  localparam logic [REG_AW-1:0] ADDR_OWN = REG_AW'(0);
  localparam logic [REG_AW-1:0] ADDR_NON = REG_AW'(1);

  logic [FLAG_W-1:0] ownFlags, nonFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownFlags <= '0;
      nonFlags <= '0;
    end else begin
      // set has priority over clear
      ownFlags <= (ownFlags & ~strobes.clrOwn) | strobes.setOwn;
      nonFlags <= (nonFlags & ~strobes.clrNon) | strobes.setNon;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_OWN: regRdata[FLAG_W-1:0] = ownFlags;
      ADDR_NON: regRdata[FLAG_W-1:0] = nonFlags;
      default:  regRdata = '0;
    endcase
  end

  for (genvar b = 0; b < FLAG_W; b++) begin : g_flagChk
    // R11: a set strobe always leaves the flag at 1
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setOwn[b] |=> ownFlags[b]);
    a_r11_set_wins_non: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setNon[b] |=> nonFlags[b]);
    // R10: a set flag holds until its own clear bit arrives
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
      (ownFlags[b] && !strobes.clrOwn[b]) |=> ownFlags[b]);
    a_r10_sticky_non: assert property (@(posedge clk) disable iff (!rstN)
      (nonFlags[b] && !strobes.clrNon[b]) |=> nonFlags[b]);
    // R9: flags rise only through a violation
    a_r9_rise_needs_set: assert property (@(posedge clk) disable iff (!rstN)
      (!ownFlags[b] && !strobes.setOwn[b]) |=> !ownFlags[b]);
  end
endmodule

// File: rtl/ram_access_guard.sv
module ram_access_guard
  import ram_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int REG_AW = 2,
  parameter int DATA_W = 32,
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuValid,
  input  logic [1:0]            cpuKind,
  input  logic [IDX_W-1:0]      cpuBlock,
  input  logic                  dmaValid,
  input  logic                  dmaWrite,
  input  logic [IDX_W-1:0]      dmaBlock,
  input  logic [NUM_BLOCKS-1:0] cfgCpuWrProt,
  input  logic [NUM_BLOCKS-1:0] cfgDmaWrProt,
  input  logic [NUM_BLOCKS-1:0] cfgFetchProt,
  input  logic [NUM_BLOCKS-1:0] cfgOtherOwns,
  output logic                  ramCpuWe,
  output logic                  ramDmaWe,
  output logic                  fetchFault,
  input  logic                  regSel,
  input  logic                  regWr,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata
);
  guard_strobe_t strobes;

  ram_guard_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W), .REG_AW(REG_AW), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuKind(cpuKind), .cpuBlock(cpuBlock),
    .dmaValid(dmaValid), .dmaWrite(dmaWrite), .dmaBlock(dmaBlock),
    .cfgCpuWrProt(cfgCpuWrProt), .cfgDmaWrProt(cfgDmaWrProt),
    .cfgFetchProt(cfgFetchProt), .cfgOtherOwns(cfgOtherOwns),
    .regSel(regSel), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .ramCpuWe(ramCpuWe), .ramDmaWe(ramDmaWe), .fetchFault(fetchFault),
    .strobes(strobes)
  );

  ram_guard_flags #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_flags (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .regAddr(regAddr), .regRdata(regRdata)
  );
endmodule

// File: tb/tb_ram_access_guard.sv
module tb_ram_access_guard;
  localparam int NB = 8;
  localparam int IW = 3;
  localparam int NVEC = 14;

  logic clk = 0, rstN = 0;
  logic cpuValid = 0; logic [1:0] cpuKind = 0; logic [IW-1:0] cpuBlock = 0;
  logic dmaValid = 0, dmaWrite = 0; logic [IW-1:0] dmaBlock = 0;
  // block 1: cpu wr, 2: dma wr, 3: fetch, 4: foreign + all, 5: all
  logic [NB-1:0] cfgCpuWrProt = 8'b0011_0010;
  logic [NB-1:0] cfgDmaWrProt = 8'b0011_0100;
  logic [NB-1:0] cfgFetchProt = 8'b0011_1000;
  logic [NB-1:0] cfgOtherOwns = 8'b0001_0000;
  logic ramCpuWe, ramDmaWe, fetchFault;
  logic regSel = 0, regWr = 0; logic [1:0] regAddr = 0; logic [31:0] regWdata = 0;
  logic [31:0] regRdata;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ram_access_guard #(.NUM_BLOCKS(NB)) dut (.*);

  typedef struct packed {
    logic cpuV; logic [1:0] kind; logic [2:0] cBlk;
    logic dmaV; logic [2:0] dBlk;
    logic eCpuWe; logic eDmaWe; logic eFault;
    logic [2:0] eOwn; logic [2:0] eNon; logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd1, 3'd0, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 4'd9},  // R9
    '{1'b0, 2'd0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 4'd9},  // R9
    '{1'b1, 2'd1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd4, 3'd0, 4'd3},  // R3
    '{1'b0, 2'd0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 3'd2, 3'd0, 4'd4},  // R4
    '{1'b1, 2'd2, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd1, 3'd0, 4'd5},  // R5
    '{1'b1, 2'd2, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 4'd9},  // R9
    '{1'b0, 2'd0, 3'd0, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 3'd0, 3'd2, 4'd6},  // R6
    '{1'b1, 2'd2, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 3'd1, 4'd7},  // R7
    '{1'b1, 2'd1, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd4, 4'd8},  // R8
    '{1'b1, 2'd0, 3'd5, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 4'd12}, // R12
    '{1'b1, 2'd1, 3'd5, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 3'd6, 3'd0, 4'd3},  // R3, R4
    '{1'b1, 2'd2, 3'd5, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 3'd1, 3'd2, 4'd6},  // R6, R5
    '{1'b1, 2'd1, 3'd2, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 4'd9},  // R9
    '{1'b0, 2'd0, 3'd0, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 3'd0, 3'd0, 4'd9}   // R9
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; regSel = 1; regWr = 0;
    #1 d = regRdata;
    regSel = 0;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regSel = 1; regWr = 1;
    @(negedge clk);
    regSel = 0; regWr = 0; regWdata = 0;
  endtask

  task automatic idleAccess();
    cpuValid = 0; cpuKind = 0; cpuBlock = 0;
    dmaValid = 0; dmaWrite = 0; dmaBlock = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    readReg(0, d); check("R1 owner after reset", d, 0);
    readReg(1, d); check("R1 foreign after reset", d, 0);

    foreach (VECS[i]) begin
      @(negedge clk);
      cpuValid = VECS[i].cpuV; cpuKind = VECS[i].kind; cpuBlock = VECS[i].cBlk;
      dmaValid = VECS[i].dmaV; dmaWrite = VECS[i].dmaV; dmaBlock = VECS[i].dBlk;
      #1;
      check($sformatf("R%0d v%0d cpuWe", VECS[i].req, i), 32'(ramCpuWe), 32'(VECS[i].eCpuWe));
      check($sformatf("R%0d v%0d dmaWe", VECS[i].req, i), 32'(ramDmaWe), 32'(VECS[i].eDmaWe));
      check($sformatf("R%0d v%0d fault", VECS[i].req, i), 32'(fetchFault), 32'(VECS[i].eFault));
      @(negedge clk);
      idleAccess();
      readReg(0, d); check($sformatf("R%0d v%0d owner", VECS[i].req, i), d, 32'(VECS[i].eOwn));
      readReg(1, d); check($sformatf("R%0d v%0d foreign", VECS[i].req, i), d, 32'(VECS[i].eNon));
      writeReg(2, 32'h7);
      writeReg(3, 32'h7);
    end

    // R10 sticky and clear rules, R2 layout and clear readback
    @(negedge clk);
    cpuValid = 1; cpuKind = 1; cpuBlock = 1;
    @(negedge clk);
    idleAccess();
    repeat (3) @(negedge clk);
    readReg(0, d); check("R10 held after idle", d, 32'h4);
    readReg(2, d); check("R2 owner clear reads 0", d, 0);
    readReg(3, d); check("R2 foreign clear reads 0", d, 0);
    writeReg(2, 32'hFFFF_FFFB);
    readReg(0, d); check("R10 zero clear bit no effect", d, 32'h4);
    writeReg(0, 32'h0);
    readReg(0, d); check("R10 write to flag reg ignored", d, 32'h4);
    writeReg(3, 32'h7);
    readReg(0, d); check("R10 other clear reg ignored", d, 32'h4);
    writeReg(2, 32'h4);
    readReg(0, d); check("R10 write one clears", d, 0);

    // R11 set wins over same-cycle clear
    @(negedge clk);
    cpuValid = 1; cpuKind = 1; cpuBlock = 1;
    @(negedge clk);
    cpuBlock = 1;
    regAddr = 2; regWdata = 32'h4; regSel = 1; regWr = 1;
    @(negedge clk);
    idleAccess(); regSel = 0; regWr = 0;
    readReg(0, d); check("R11 set beats clear", d, 32'h4);

    // R1 reset mid-run
    @(negedge clk);
    dmaValid = 1; dmaWrite = 1; dmaBlock = 4;
    @(negedge clk);
    idleAccess();
    readReg(1, d); check("R6 foreign set before reset", d, 32'h2);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    readReg(0, d); check("R1 owner after second reset", d, 0);
    readReg(1, d); check("R1 foreign after second reset", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule